// File: doc/BRIEF.md
# Dual-Bank Q Subcode Buffer

This block collects the 80-bit Q subcode word of an optical-disc decoder, one bit per frame, and presents finished words to a host processor. Two 80-bit banks take turns. One bank is filled from the decoder's Q bit stream. The other bank holds the last word that passed its CRC, and the host shifts that word out on a clock of its own. Because the host reads a stable bank while the next word is written, it can read at any pace up to one word per subcode block.

The banks change roles when the sync indication and the CRC-pass flag are high together. A word that fails its CRC is never shown to the host. Bits are placed so that each 4-bit nibble leaves least significant bit first, and the host can use each nibble as it arrives. A mode input selects a second path. In direct mode each incoming Q bit is driven out at once, followed by a one-cycle strobe that the block generates.

The Q input has no ready signal. The block accepts every `q_valid` pulse, and the frame source never sees back-pressure. A host that reads too slowly only delays the next bank swap, as R7 describes.

Top module: `qsub_buffer`

## Requirements
- R1: After synchronous reset, `q_out` and `strobe_out` are 0. In buffered mode `q_out` stays 0 until the first bank swap.
- R2: Each `q_valid` pulse stores `q_bit` in the write bank. The n-th bit of a word (n = 0..79) reaches the host at readout position 4*(n/4) + 3 - (n mod 4), so the bits of each nibble are reversed.
- R3: When `sync_flag` and `crc_ok` become high together and no host read is in progress, the banks swap. On the next clock `q_out` shows readout position 0 of the new read bank.
- R4: A sync without `crc_ok` never swaps the banks. The data the host reads is not changed by it.
- R5: Each rising edge of `host_clk` moves the readout forward by one position. `q_out` shows the new bit no later than three `clk` rising edges after the `host_clk` edge.
- R6: After the host has stepped 80 times, `q_out` stays 0 until the next swap.
- R7: A swap that is requested while a read is partly done (1 to 79 steps taken) is held back. `q_out` keeps following the old word. The held swap is taken on the cycle after the 80th step. Writes are blocked while the swap is held and after it is taken, until the next sync.
- R8: With `mode_direct` = 1, each `q_valid` pulse drives `q_bit` onto `q_out` on the next clock edge.
- R9: In direct mode `strobe_out` is high for exactly one cycle, starting one cycle after the bit appears on `q_out`. In buffered mode `strobe_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_direct | input | 1 | 0 = buffered host readout, 1 = direct per-frame output |
| q_valid | input | 1 | One-cycle pulse per frame marking a valid Q bit |
| q_bit | input | 1 | Q subcode bit from the decoder |
| sync_flag | input | 1 | Subcode block sync; its rising edge starts a new word |
| crc_ok | input | 1 | High when the word just completed passed its CRC |
| host_clk | input | 1 | Host read clock, asynchronous to `clk` |
| q_out | output | 1 | Serial Q data for the host, or the direct bit |
| strobe_out | output | 1 | Strobe generated for direct mode |

## Verification
The sync and CRC-pass inputs take effect on the same clock edge that samples them, so the bench checks a swap at the falling edge that follows. A `host_clk` rising edge passes through two synchroniser flops and an edge detector, so the readout moves on the third `clk` edge. The bench holds each host clock level for four cycles and samples after them. In direct mode the bit is due one edge after its `q_valid` and the strobe one edge later. The bench reads the outputs at successive falling edges, so it can check the strobe's rise and fall in the exact cycles.

// File: rtl/qsb_pkg.sv
package qsb_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } qsb_bank_e;

  typedef enum logic {
    MODE_BUFFERED = 1'b0,
    MODE_DIRECT   = 1'b1
  } qsb_mode_e;

endpackage

// File: rtl/qsb_host_sync.sv
module qsb_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic host_clk,
  output logic step
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], host_clk};
  end

  assign step = chain[STAGES-1] & ~chain[STAGES];

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

endmodule

// File: rtl/qsb_bank_ctrl.sv
module qsb_bank_ctrl
  import qsb_pkg::*;
#(
  parameter int NIBBLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic q_valid,
  input  logic q_bit,
  input  logic sync_flag,
  input  logic crc_ok,
  input  logic host_step,
  output logic rd_bit
);
  localparam int WORD = NIBBLES * 4;
  localparam int PW   = $clog2(WORD + 1);
  localparam logic [PW-1:0] FULL = PW'(WORD);

  logic [1:0][WORD-1:0] banks;
  qsb_bank_e            wr_sel;
  logic [PW-1:0]        wr_ptr, rd_ptr;
  logic                 pend, sync_d, good_d;

  logic          good, good_rise, sync_rise, busy, take, wr_en;
  logic [PW-1:0] wr_addr;

  assign good      = sync_flag & crc_ok;
  assign good_rise = good & ~good_d;
  assign sync_rise = sync_flag & ~sync_d;
  assign busy      = (rd_ptr != '0) && (rd_ptr != FULL);
  assign take      = (good_rise | pend) & ~busy;
  assign wr_en     = q_valid && (wr_ptr != FULL) && !pend;
  // reverse bit order inside each nibble
  assign wr_addr   = {wr_ptr[PW-1:2], ~wr_ptr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      banks  <= '0;
      wr_sel <= BANK_A;
      wr_ptr <= '0;
      rd_ptr <= FULL;
      pend   <= 1'b0;
      sync_d <= 1'b0;
      good_d <= 1'b0;
    end else begin
      sync_d <= sync_flag;
      good_d <= good;
      if (take) begin
        wr_sel <= (wr_sel == BANK_A) ? BANK_B : BANK_A;
        rd_ptr <= '0;
        pend   <= 1'b0;
        // a deferred swap leaves the write bank idle until the next sync
        wr_ptr <= pend ? FULL : '0;
      end else begin
        if (good_rise) begin
          pend <= 1'b1;
        end else if (sync_rise && !pend) begin
          wr_ptr <= '0;
        end else if (wr_en) begin
          banks[wr_sel == BANK_B][wr_addr] <= q_bit;
          wr_ptr <= wr_ptr + 1'b1;
        end
        if (host_step && rd_ptr != FULL) rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  assign rd_bit = (rd_ptr != FULL) ? banks[wr_sel == BANK_A][rd_ptr] : 1'b0;

  // R6
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ptr <= FULL);

  // R5
  rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr != $past(rd_ptr) && rd_ptr != '0) |-> $past(host_step));

  // R7
  no_swap_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != $past(wr_sel)) |-> ($past(rd_ptr) == '0 || $past(rd_ptr) == FULL));

  // R4
  swap_needs_crc_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != $past(wr_sel)) |-> ($past(crc_ok) || $past(pend)));

  // R3
  swap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != $past(wr_sel)) |-> (rd_ptr == '0));

endmodule

// File: rtl/qsb_direct.sv
module qsb_direct (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic q_valid,
  input  logic q_bit,
  output logic d_bit,
  output logic strobe
);
  logic latched;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_bit   <= 1'b0;
      latched <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      latched <= en & q_valid;
      strobe  <= latched;
      if (en && q_valid) d_bit <= q_bit;
    end
  end

  // R9
  strobe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(en && q_valid, 2));

endmodule

// File: rtl/qsub_buffer.sv
module qsub_buffer
  import qsb_pkg::*;
#(
  parameter int NIBBLES     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_direct,
  input  logic q_valid,
  input  logic q_bit,
  input  logic sync_flag,
  input  logic crc_ok,
  input  logic host_clk,
  output logic q_out,
  output logic strobe_out
);
  qsb_mode_e mode;
  logic      host_step, rd_bit, d_bit, d_strobe;

  assign mode = qsb_mode_e'(mode_direct);

  qsb_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .host_clk(host_clk), .step(host_step)
  );

  qsb_bank_ctrl #(.NIBBLES(NIBBLES)) u_banks (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_bit(q_bit),
    .sync_flag(sync_flag), .crc_ok(crc_ok), .host_step(host_step),
    .rd_bit(rd_bit)
  );

  qsb_direct u_direct (
    .clk(clk), .rst(rst), .en(mode == MODE_DIRECT), .q_valid(q_valid),
    .q_bit(q_bit), .d_bit(d_bit), .strobe(d_strobe)
  );

  assign q_out      = (mode == MODE_DIRECT) ? d_bit : rd_bit;
  assign strobe_out = (mode == MODE_DIRECT) ? d_strobe : 1'b0;

  // R9
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_out |-> mode_direct);

endmodule

// File: tb/qsub_buffer_test.sv
module qsub_buffer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_direct = 1'b0, q_valid = 1'b0, q_bit = 1'b0;
  logic sync_flag = 1'b0, crc_ok = 1'b0, host_clk = 1'b0;
  logic q_out, strobe_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qsub_buffer uut (
    .clk(clk), .rst(rst), .mode_direct(mode_direct), .q_valid(q_valid),
    .q_bit(q_bit), .sync_flag(sync_flag), .crc_ok(crc_ok),
    .host_clk(host_clk), .q_out(q_out), .strobe_out(strobe_out)
  );

  // {crc_ok at closing sync, 80-bit word; bit i is the i-th bit sent}
  localparam logic [80:0] VECS [0:3] = '{
    {1'b1, 80'h1234_5678_9ABC_DEF0_0F1E},
    {1'b1, 80'hFFFF_0000_A5A5_5A5A_C3C3},
    {1'b0, 80'hDEAD_BEEF_CAFE_F00D_7777},
    {1'b1, 80'h8001_4002_2004_1008_0FF0}
  };

  function automatic logic [79:0] reorder(input logic [79:0] w);
    logic [79:0] r;
    for (int k = 0; k < 80; k++) r[k] = w[4*(k/4) + 3 - (k%4)];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [79:0] act,
                       input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); q_valid = 1'b1; q_bit = b;
    @(negedge clk); q_valid = 1'b0;
  endtask

  task automatic send_word(input logic [79:0] w);
    for (int i = 0; i < 80; i++) send_bit(w[i]);
  endtask

  task automatic pulse_sync(input logic c);
    @(negedge clk); sync_flag = 1'b1; crc_ok = c;
    @(negedge clk); sync_flag = 1'b0; crc_ok = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_step();
    @(negedge clk); host_clk = 1'b1;
    repeat (4) @(negedge clk);
    host_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_bits(input int n, output logic [79:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      got[k] = q_out;
      host_step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [79:0] got, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(q_out == 1'b0 && strobe_out == 1'b0, "R1 reset outputs",
          {78'b0, q_out, strobe_out}, 80'h0);
    host_step();
    check(q_out == 1'b0, "R1 no data before first swap", {79'b0, q_out}, 80'h0);

    held = '0;
    for (int e = 0; e < 4; e++) begin
      send_word(VECS[e][79:0]);
      pulse_sync(VECS[e][80]);
      if (VECS[e][80]) held = reorder(VECS[e][79:0]);
      else held = '0;  // previous word fully read, failed word must not appear
      read_bits(80, got);
      // R2 R3 R4 R5 readout order and swap gating
      check(got == held, $sformatf("R2/R3/R4/R5 vector %0d readout", e), got, held);
      check(q_out == 1'b0, "R6 hold zero after 80 steps", {79'b0, q_out}, 80'h0);
    end

    // R7 deferred swap
    send_word(80'h0123_4567_89AB_CDEF_1357);
    pulse_sync(1'b1);
    held = reorder(80'h0123_4567_89AB_CDEF_1357);
    read_bits(10, got);
    check(got[9:0] == held[9:0], "R5 partial read", {70'b0, got[9:0]},
          {70'b0, held[9:0]});
    send_word(80'hF0E1_D2C3_B4A5_9687_7869);
    pulse_sync(1'b1);
    check(q_out == held[10], "R7 swap held during read", {79'b0, q_out},
          {79'b0, held[10]});
    host_step();
    check(q_out == held[11], "R7 old word continues", {79'b0, q_out},
          {79'b0, held[11]});
    for (int k = 12; k < 80; k++) host_step();
    host_step();
    held = reorder(80'hF0E1_D2C3_B4A5_9687_7869);
    check(q_out == held[0], "R7 deferred swap taken after 80th step",
          {79'b0, q_out}, {79'b0, held[0]});
    read_bits(80, got);
    check(got == held, "R7 deferred word readout", got, held);

    // R7 writes stay blocked until the next sync
    send_word(80'hAAAA_AAAA_AAAA_AAAA_AAAA);
    pulse_sync(1'b0);
    send_word(80'h5A5A_0000_FFFF_1234_4321);
    pulse_sync(1'b1);
    held = reorder(80'h5A5A_0000_FFFF_1234_4321);
    read_bits(80, got);
    check(got == held, "R7 realigned after deferred swap", got, held);

    // R8 R9 direct mode
    mode_direct = 1'b1;
    @(negedge clk); q_valid = 1'b1; q_bit = 1'b1;
    @(negedge clk); q_valid = 1'b0; q_bit = 1'b0;
    check(q_out == 1'b1 && strobe_out == 1'b0, "R8 direct bit one",
          {78'b0, q_out, strobe_out}, 80'h2);
    @(negedge clk);
    check(q_out == 1'b1 && strobe_out == 1'b1, "R9 strobe one cycle later",
          {78'b0, q_out, strobe_out}, 80'h3);
    @(negedge clk);
    check(strobe_out == 1'b0, "R9 strobe single cycle", {79'b0, strobe_out}, 80'h0);
    @(negedge clk); q_valid = 1'b1; q_bit = 1'b0;
    @(negedge clk); q_valid = 1'b0;
    check(q_out == 1'b0, "R8 direct bit zero", {79'b0, q_out}, 80'h0);
    @(negedge clk);
    check(strobe_out == 1'b1, "R9 strobe for second bit", {79'b0, strobe_out}, 80'h1);
    mode_direct = 1'b0;
    @(negedge clk); q_valid = 1'b1;
    @(negedge clk); q_valid = 1'b0;
    @(negedge clk);
    check(strobe_out == 1'b0, "R9 no strobe in buffered mode", {79'b0, strobe_out}, 80'h0);

    // R1 reset mid-operation
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(q_out == 1'b0 && strobe_out == 1'b0, "R1 reset clears outputs",
          {78'b0, q_out, strobe_out}, 80'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule